// File: doc/BRIEF.md
# Dual-Mode Timer with Buffered High Byte

This block is a byte-programmable timer/counter built from a low counter byte and a high counter byte. A mode bit picks how they work together. In 8-bit mode the low byte counts up to a period value and then clears. That period value is held in a buffer register and copied into the active compare byte. In 16-bit mode the two bytes form one free-running counter that wraps from 0xFFFF to 0x0000. In this mode the buffer register acts as a holding latch. Software reads and writes the full 16-bit value through it in one step, by accessing the low byte.

Count ticks come from either the system clock or a single-cycle enable input, `ext_tick`. They then pass through a power-of-two prescaler with a 15-bit counter. Each match or wrap event drives the `match_out` pulse for exactly one count. A postscaler gathers these events and sets a sticky interrupt flag on every Nth one. Software clears the flag.

Top module: `dual_mode_timer`

Register map, selected by `addr`:
- 0: low counter byte.
- 1: period/high buffer.
- 2: control A, with en[7], flag[5], mode16[4] and post_sel[3:0].
- 3: control B, with ext_sel[6] and pre_sel[3:0].

## Requirements
- R1: After reset every register reads 0 at all four addresses, and `irq` and `match_out` are low.
- R2: While control A bit 7 (enable) is 0, the counter holds its value, whatever `ext_tick` does.
- R3: In 8-bit mode (control A bit 4 = 0), with period P held in the active compare byte, the low byte counts 0..P and clears on the next count. Matches are therefore (P+1)·2^pre_sel clock ticks apart, and `match_out` stays high for one count, which is 2^pre_sel ticks.
- R4: In 8-bit mode a new period written to address 1 takes effect only at the next match, or at the next write of address 0.
- R5: In 16-bit mode a read of address 0 (with `rd_en`) copies the counter's high byte into the buffer at that same edge. A later read of address 1 then returns the high byte that pairs with the low byte already read.
- R6: A write to address 0 loads the low byte from `wdata` and copies the buffer into the counter's high byte at the same edge.
- R7: In 16-bit mode a wrap from 0xFFFF to 0x0000 counts as an event.
- R8: The counter advances once every 2^pre_sel selected ticks (control B bits 3:0). A write of address 0 restarts the prescaler, so the next count comes 2^pre_sel ticks later.
- R9: When control B bit 6 is 1, only cycles with `ext_tick` high count as ticks. When it is 0, every clock cycle is a tick.
- R10: The flag (control A bit 5, also driven on `irq`) sets on every Nth event, where N = post_sel+1 (1..16). A write of address 0 restarts the event count.
- R11: Writing control A with bit 5 = 0 clears the flag. Writing bit 5 = 1 leaves the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_tick | input | 1 | Alternate tick source, one cycle per tick |
| addr | input | 2 | Register select |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Read strobe (triggers the high-byte capture) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| match_out | output | 1 | High for one count on each match or wrap |
| irq | output | 1 | Sticky interrupt flag |

## Verification
The bench builds the block with its default parameters: a 15-bit prescaler and a 4-bit postscaler. This makes every divide value from 1 to 16 reachable, so the bench tests both postscaler ends (1 and 16) as well as random values in between. Random prescaler exponents stay between 0 and 3 to keep runs short. With that range, both the period formula and the stretched match pulse are still measured in cycles, for random periods. Random 16-bit loads are checked against their exact count after a known number of ticks, including loads near a low-byte carry.

// File: rtl/dual_mode_timer.sv
module dual_mode_timer #(
  parameter int PRE_W  = 15,
  parameter int POST_W = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ext_tick,
  input  logic [1:0] addr,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       match_out,
  output logic       irq
);
  localparam int SEL_W = $clog2(PRE_W + 1);

  logic              en, mode16, flag, ext_sel;
  logic [POST_W-1:0] post_sel, post_cnt;
  logic [SEL_W-1:0]  pre_sel;
  logic [PRE_W-1:0]  pre_cnt, pre_mask;
  logic [7:0]        cnt_lo, cnt_hi, buf_hi;

  wire wr_lo  = wr_en && addr == 2'd0;
  wire wr_hi  = wr_en && addr == 2'd1;
  wire wr_ca  = wr_en && addr == 2'd2;
  wire wr_cb  = wr_en && addr == 2'd3;
  wire rd_lo  = rd_en && addr == 2'd0;

  wire src_tick = en && (!ext_sel || ext_tick);
  assign pre_mask = PRE_W'((33'd1 << pre_sel) - 33'd1);
  wire cnt_tick = src_tick && ((pre_cnt & pre_mask) == pre_mask);
  wire hit8     = !mode16 && cnt_lo == cnt_hi;
  wire wrap16   = mode16 && {cnt_hi, cnt_lo} == 16'hFFFF;
  wire evt      = cnt_tick && !wr_lo && (hit8 || wrap16);
  wire post_hit = post_cnt == post_sel;

  assign irq = flag;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        pre_cnt <= '0;
    else if (wr_lo)    pre_cnt <= '0;
    else if (src_tick) pre_cnt <= pre_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt_lo <= '0;
      cnt_hi <= '0;
    end else if (wr_lo) begin
      cnt_lo <= wdata;
      cnt_hi <= buf_hi;
    end else if (cnt_tick) begin
      if (mode16)    {cnt_hi, cnt_lo} <= {cnt_hi, cnt_lo} + 16'd1;
      else if (hit8) begin
        cnt_lo <= '0;
        cnt_hi <= buf_hi;
      end else       cnt_lo <= cnt_lo + 8'd1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                buf_hi <= '0;
    else if (wr_hi)            buf_hi <= wdata;
    else if (rd_lo && mode16)  buf_hi <= cnt_hi;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        match_out <= 1'b0;
    else if (wr_lo)    match_out <= 1'b0;
    else if (cnt_tick) match_out <= hit8 || wrap16;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     post_cnt <= '0;
    else if (wr_lo) post_cnt <= '0;
    else if (evt)   post_cnt <= post_hit ? '0 : post_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                  flag <= 1'b0;
    else if (evt && post_hit)    flag <= 1'b1;
    else if (wr_ca && !wdata[5]) flag <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en       <= 1'b0;
      mode16   <= 1'b0;
      post_sel <= '0;
      ext_sel  <= 1'b0;
      pre_sel  <= '0;
    end else begin
      if (wr_ca) begin
        en       <= wdata[7];
        mode16   <= wdata[4];
        post_sel <= POST_W'(wdata[3:0]);
      end
      if (wr_cb) begin
        ext_sel <= wdata[6];
        pre_sel <= SEL_W'(wdata[3:0]);
      end
    end

  always_comb
    case (addr)
      2'd0:    rdata = cnt_lo;
      2'd1:    rdata = buf_hi;
      2'd2:    rdata = {en, 1'b0, flag, mode16, 4'(post_sel)};
      default: rdata = {1'b0, ext_sel, 2'b00, 4'(pre_sel)};
    endcase

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en && !wr_lo |=> $stable(cnt_lo) && $stable(cnt_hi));

  a_r3_match_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(match_out) && !mode16 |-> cnt_lo == 8'd0);

  a_r5_capture: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lo && mode16 && !wr_en |=> buf_hi == $past(cnt_hi));

  a_r6_atomic_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> cnt_lo == $past(wdata) && cnt_hi == $past(buf_hi));

  a_r8_pre_restart: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> pre_cnt == '0 && !match_out);

  a_r11_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !(wr_ca && !wdata[5]) |=> irq);
endmodule

// File: tb/dual_mode_timer_test.sv
module dual_mode_timer_test;
  logic       clk = 0, rst_n = 0, ext_tick = 0, wr_en = 0, rd_en = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic       match_out, irq;
  int tests = 0, fails = 0;

  dual_mode_timer uut (.clk, .rst_n, .ext_tick, .addr, .wr_en, .rd_en,
                       .wdata, .rdata, .match_out, .irq);

  always #4 clk = ~clk;

  function automatic int exp_gap(input int per, input int pre);
    return (per + 1) << pre;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; rd_en = 1; #1; v = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic wait_rise(output int n);
    logic prev, hit;
    n = 0; prev = match_out;
    do begin
      @(negedge clk); n++;
      hit = !prev && match_out; prev = match_out;
    end while (!hit);
  endtask

  task automatic period(output int gap, output int width);
    logic hi = 1;
    gap = 0; width = 1;
    do begin
      @(negedge clk); gap++;
      if (match_out && hi) width++;
      if (!match_out) hi = 0;
    end while (!(match_out && !hi));
  endtask

  task automatic setup8(input int per, input int pre, input logic ext, input int n);
    wr(2, 8'h00);
    wr(1, 8'(per));
    wr(3, {1'b0, ext, 2'b00, 4'(pre)});
    wr(0, 8'h00);
    wr(2, {1'b1, 3'b000, 4'(n - 1)});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] v, v2, lo, hi;
    int n, g, w, cnt, per, pre, k, r;
    logic [15:0] base, got;
    void'($urandom(32'd20917));
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      peek(2'(a), v);
      chk("R1 reg", v, 0);
    end
    chk("R1 irq", irq, 0);
    chk("R1 match_out", match_out, 0);

    // R3 directed and random periods
    setup8(4, 0, 0, 1);
    wait_rise(n);
    period(g, w);
    chk("R3 gap P=4", g, exp_gap(4, 0));
    chk("R3 width P=4", w, 1);
    for (int i = 0; i < 6; i++) begin
      per = $urandom_range(1, 12);
      pre = $urandom_range(0, 3);
      setup8(per, pre, 0, 1);
      wait_rise(n);
      period(g, w);
      chk("R3 R8 random gap", g, exp_gap(per, pre));
      chk("R3 R8 random width", w, 1 << pre);
    end

    // R4 period change takes effect at next match
    setup8(4, 0, 0, 1);
    wait_rise(n);
    wr(1, 8'd9);
    wait_rise(n);
    chk("R4 old period still active", int'(n <= 5), 1);
    period(g, w);
    chk("R4 new period gap", g, exp_gap(9, 0));

    // R8 write of low byte restarts prescaler
    setup8(200, 3, 0, 1);
    repeat (13) @(negedge clk);
    wr(0, 8'h00);
    repeat (7) @(negedge clk);
    peek(0, v);
    chk("R8 no count before 8 ticks", v, 0);
    @(negedge clk);
    peek(0, v);
    chk("R8 count at 8th tick", v, 1);

    // R9 external tick source
    setup8(250, 0, 1, 1);
    k = $urandom_range(3, 20);
    for (int i = 0; i < k; i++) begin
      @(negedge clk); ext_tick = 1;
      @(negedge clk); ext_tick = 0;
      repeat ($urandom_range(0, 3)) @(negedge clk);
    end
    peek(0, v);
    chk("R9 ext ticks counted", v, k);

    // R2 disabled counter holds
    wr(2, 8'h00);
    peek(0, v);
    repeat (10) begin
      @(negedge clk); ext_tick = ~ext_tick;
    end
    ext_tick = 0;
    peek(0, v2);
    chk("R2 hold while disabled", v2, v);

    // R5 R6 directed, counter stopped in 16-bit mode
    wr(3, 8'h00);
    wr(2, 8'h10);
    wr(1, 8'hAB);
    wr(0, 8'hCD);
    wr(1, 8'h11);
    rd(0, lo);
    rd(1, hi);
    chk("R6 low byte loaded", lo, 8'hCD);
    chk("R5 R6 high byte captured", hi, 8'hAB);

    // R5 R6 random running 16-bit values, one near a low carry
    for (int i = 0; i < 6; i++) begin
      base = (i == 0) ? 16'h12FC : 16'($urandom);
      r = $urandom_range(0, 20);
      wr(2, 8'h10);
      wr(1, base[15:8]);
      wr(0, base[7:0]);
      wr(2, 8'h90);
      repeat (r) @(negedge clk);
      rd(0, lo);
      rd(1, hi);
      got = {hi, lo};
      chk("R5 R6 16-bit pair", got, 16'(base + 16'(r + 1)));
    end

    // R7 wrap event in 16-bit mode
    wr(2, 8'h10);
    wr(1, 8'hFF);
    wr(0, 8'hF0);
    wr(2, 8'h90);
    repeat (5) @(negedge clk);
    chk("R7 no flag before wrap", irq, 0);
    repeat (30) @(negedge clk);
    chk("R7 flag after wrap", irq, 1);
    wr(2, 8'h10);
    rd(0, lo);
    rd(1, hi);
    chk("R7 high byte wrapped", hi, 0);

    // R10 postscaler ends and random N
    for (int i = 0; i < 5; i++) begin
      logic prev;
      n = (i == 0) ? 1 : (i == 1) ? 16 : $urandom_range(2, 15);
      setup8(1, 0, 0, n);
      cnt = 0; prev = 0;
      do begin
        @(negedge clk);
        if (!prev && match_out) cnt++;
        prev = match_out;
      end while (!irq);
      chk("R10 events to flag", cnt, n);
    end

    // R11 flag clear semantics
    wr(2, 8'h20);
    repeat (5) @(negedge clk);
    chk("R11 write 1 keeps flag", irq, 1);
    peek(2, v);
    chk("R11 flag readable", v[5], 1);
    wr(2, 8'h00);
    chk("R11 write 0 clears", irq, 0);
    wr(2, 8'h20);
    chk("R11 write 1 does not set", irq, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule